// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Interface

This block is the software-visible register file of a four-channel DMA controller. A host reaches it through a narrow I/O bus. That bus has a 4-bit port offset, separate read and write strobes, and 8-bit data. Each channel keeps a 16-bit base address, a 16-bit current address, a 16-bit base count, a 16-bit current count and a mode byte. The controller as a whole keeps a command byte, a status byte, a 4-bit request set, a 4-bit mask and a temporary byte.

All 16-bit quantities are moved one byte at a time. A single shared byte pointer decides whether an access touches the low byte or the high byte. The pointer is a two-state machine with the states FF_LOW and FF_HIGH. Any address or count access takes it from one state to the other. A pointer-clear write or a master reset forces it to FF_LOW.

The mask has four ways to change:
- a single-channel set or clear;
- a whole-mask load;
- a clear-all port;
- master reset, which sets every bit.

The transfer engine sits outside this block and pushes in three things: new current address and count values, the status byte and the temporary byte. All register contents are driven out continuously for that engine.

Top module: `dma_reg_if`

## Requirements
- R1: After reset, all addresses, counts, modes, the command byte, the status byte, the requests and the temporary byte are zero. The mask is 0xF and the byte pointer is in FF_LOW.
- R2: A write to port 0, 2, 4 or 6 selects channel port[2:1]. It loads the data byte into both the base address and the current address of that channel: the low byte in FF_LOW, the high byte in FF_HIGH.
- R3: A write to port 1, 3, 5 or 7 loads the byte selected by the pointer into both the base count and the current count of channel port[2:1]. A read of ports 0 to 7 returns the byte of the current address (even port) or current count (odd port) that the pointer selects.
- R4: The pointer toggles after every read or write of ports 0 to 7. A write to port 0xC forces it to FF_LOW.
- R5: A write to port 0xB stores data with bits 1:0 cleared as the mode of channel data[1:0].
- R6: A write to port 0xA affects mask bit data[1:0] only. It sets that bit when data[2] is 1 and clears it when data[2] is 0.
- R7: A write to port 0xF loads the mask with data[3:0]. A read of port 0xF returns {4'b0, mask}.
- R8: A write to port 0xD clears the command byte, the status byte, the requests and the pointer, and sets the mask to 0xF. A read of port 0xD returns the temporary byte.
- R9: A write to port 0xE clears the mask.
- R10: A write to port 0x8 loads the command byte, and a read of port 0x8 returns the status byte. A write to port 0x9 sets request bit data[1:0] when data[2] is 1 and clears it when data[2] is 0. Reads of ports 0x9, 0xA, 0xB, 0xC and 0xE return 0x00.
- R11: An engine update loads the current address and current count of channel eng_chan. When a port write hits the same register in the same cycle, the port write wins for that whole register.
- R12: An engine status load replaces the status byte, unless a master reset happens in the same cycle, in which case the status byte becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_port | input | 4 | Port offset |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_port (combinational) |
| eng_upd | input | 1 | Engine current-register update |
| eng_chan | input | 2 | Channel targeted by the engine |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| eng_sts_wr | input | 1 | Status load strobe |
| eng_sts | input | 8 | Status value |
| eng_tmp_wr | input | 1 | Temporary-byte load strobe |
| eng_tmp | input | 8 | Temporary value |
| cmd_o | output | 8 | Command byte |
| req_o | output | 4 | Request bits |
| mask_o | output | 4 | Mask bits |
| mode_o | output | 32 | Mode bytes, channel n at [8n+7:8n] |
| base_addr_o | output | 64 | Base addresses, channel n at [16n+15:16n] |
| cur_addr_o | output | 64 | Current addresses |
| base_cnt_o | output | 64 | Base counts |
| cur_cnt_o | output | 64 | Current counts |

## Verification
The two functions that can meet in one cycle are an engine update of a channel's current registers and a host write to that same channel's address or count port. Master reset and an engine status load form a second such pair. Directed cycles raise each collision on purpose. Random traffic also raises them often, because engine updates are mixed freely into port writes with random channels. A bench model decides the result. In that model the port write takes the whole targeted register and leaves the untouched register to the engine, and master reset overrides the status load.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [3:0] OFS_CMD_STS  = 4'h8;
    localparam logic [3:0] OFS_REQ      = 4'h9;
    localparam logic [3:0] OFS_MASK_ONE = 4'hA;
    localparam logic [3:0] OFS_MODE     = 4'hB;
    localparam logic [3:0] OFS_PTR_CLR  = 4'hC;
    localparam logic [3:0] OFS_MRESET   = 4'hD;
    localparam logic [3:0] OFS_MASK_CLR = 4'hE;
    localparam logic [3:0] OFS_MASK_ALL = 4'hF;

    typedef enum logic {FF_LOW, FF_HIGH} ptr_state_e;

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] old,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic hi);
        return hi ? {b, old[BYTE_W-1:0]} : {old[WORD_W-1:BYTE_W], b};
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(input logic [WORD_W-1:0] w,
                                                   input logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/dma_byte_seq.sv
module dma_byte_seq
    import dma_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic ff_hi
);
    ptr_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FF_LOW;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (clear) begin
            st_nx = FF_LOW;
        end else if (step) begin
            unique case (st)
                FF_LOW:  st_nx = FF_HIGH;
                FF_HIGH: st_nx = FF_LOW;
            endcase
        end
    end

    assign ff_hi = (st == FF_HIGH);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ff_hi,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_mode,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] mode_val,
    input  logic              eng_upd,
    input  logic [WORD_W-1:0] eng_addr,
    input  logic [WORD_W-1:0] eng_cnt,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_cnt,
    output logic [BYTE_W-1:0] mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (wr_addr) begin
                base_addr <= put_byte(base_addr, wdata, ff_hi);
                cur_addr  <= put_byte(cur_addr, wdata, ff_hi);
            end else if (eng_upd) begin
                cur_addr  <= eng_addr;
            end
            if (wr_cnt) begin
                base_cnt <= put_byte(base_cnt, wdata, ff_hi);
                cur_cnt  <= put_byte(cur_cnt, wdata, ff_hi);
            end else if (eng_upd) begin
                cur_cnt  <= eng_cnt;
            end
            if (wr_mode) mode <= mode_val;
        end
    end
endmodule

// File: rtl/dma_mask_ctl.sv
module dma_mask_ctl #(
    parameter int NCH = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            one_wr,
    input  logic            all_wr,
    input  logic            clr_wr,
    input  logic            mreset,
    input  logic [CH_W-1:0] sel,
    input  logic            set_bit,
    input  logic [NCH-1:0]  all_val,
    output logic [NCH-1:0]  mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= '1;
        else if (mreset)  mask <= '1;
        else if (clr_wr)  mask <= '0;
        else if (all_wr)  mask <= all_val;
        else if (one_wr)  mask[sel] <= set_bit;
    end
endmodule

// File: rtl/dma_reg_if.sv
module dma_reg_if
    import dma_regs_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CH_W = $clog2(NCH),
    localparam int AW = WORD_W,
    localparam int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        io_port,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [BW-1:0]     io_wdata,
    output logic [BW-1:0]     io_rdata,
    input  logic              eng_upd,
    input  logic [CH_W-1:0]   eng_chan,
    input  logic [AW-1:0]     eng_addr,
    input  logic [AW-1:0]     eng_cnt,
    input  logic              eng_sts_wr,
    input  logic [BW-1:0]     eng_sts,
    input  logic              eng_tmp_wr,
    input  logic [BW-1:0]     eng_tmp,
    output logic [BW-1:0]     cmd_o,
    output logic [NCH-1:0]    req_o,
    output logic [NCH-1:0]    mask_o,
    output logic [NCH*BW-1:0] mode_o,
    output logic [NCH*AW-1:0] base_addr_o,
    output logic [NCH*AW-1:0] cur_addr_o,
    output logic [NCH*AW-1:0] base_cnt_o,
    output logic [NCH*AW-1:0] cur_cnt_o
);
    // port decode
    logic            chan_port;
    logic [CH_W-1:0] port_ch;
    logic            wr_mreset;
    logic            ff_hi;

    assign chan_port = ~io_port[3];
    assign port_ch   = io_port[CH_W:1];
    assign wr_mreset = io_wr && (io_port == OFS_MRESET);

    dma_byte_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .step  ((io_wr || io_rd) && chan_port),
        .clear (io_wr && ((io_port == OFS_PTR_CLR) || (io_port == OFS_MRESET))),
        .ff_hi (ff_hi)
    );

    logic [AW-1:0] cur_addr_a [NCH];
    logic [AW-1:0] cur_cnt_a  [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [AW-1:0] base_addr_c, base_cnt_c;
        logic [BW-1:0] mode_c;
        dma_chan_regs u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ff_hi     (ff_hi),
            .wr_addr   (io_wr && chan_port && !io_port[0] && (port_ch == CH_W'(c))),
            .wr_cnt    (io_wr && chan_port &&  io_port[0] && (port_ch == CH_W'(c))),
            .wr_mode   (io_wr && (io_port == OFS_MODE) && (io_wdata[CH_W-1:0] == CH_W'(c))),
            .wdata     (io_wdata),
            .mode_val  ({io_wdata[BW-1:2], 2'b00}),
            .eng_upd   (eng_upd && (eng_chan == CH_W'(c))),
            .eng_addr  (eng_addr),
            .eng_cnt   (eng_cnt),
            .base_addr (base_addr_c),
            .cur_addr  (cur_addr_a[c]),
            .base_cnt  (base_cnt_c),
            .cur_cnt   (cur_cnt_a[c]),
            .mode      (mode_c)
        );
        assign base_addr_o[c*AW +: AW] = base_addr_c;
        assign cur_addr_o[c*AW +: AW]  = cur_addr_a[c];
        assign base_cnt_o[c*AW +: AW]  = base_cnt_c;
        assign cur_cnt_o[c*AW +: AW]   = cur_cnt_a[c];
        assign mode_o[c*BW +: BW]      = mode_c;
    end

    dma_mask_ctl #(.NCH(NCH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .one_wr  (io_wr && (io_port == OFS_MASK_ONE)),
        .all_wr  (io_wr && (io_port == OFS_MASK_ALL)),
        .clr_wr  (io_wr && (io_port == OFS_MASK_CLR)),
        .mreset  (wr_mreset),
        .sel     (io_wdata[CH_W-1:0]),
        .set_bit (io_wdata[2]),
        .all_val (io_wdata[NCH-1:0]),
        .mask    (mask_o)
    );

    // shared command / status / request / temporary
    logic [BW-1:0] sts_q, tmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o <= '0;
            sts_q <= '0;
            req_o <= '0;
            tmp_q <= '0;
        end else begin
            if (eng_tmp_wr) tmp_q <= eng_tmp;
            if (wr_mreset) begin
                cmd_o <= '0;
                sts_q <= '0;
                req_o <= '0;
            end else begin
                if (eng_sts_wr) sts_q <= eng_sts;
                if (io_wr && (io_port == OFS_CMD_STS)) cmd_o <= io_wdata;
                if (io_wr && (io_port == OFS_REQ)) req_o[io_wdata[CH_W-1:0]] <= io_wdata[2];
            end
        end
    end

    // read mux
    always_comb begin
        io_rdata = '0;
        if (chan_port) begin
            io_rdata = io_port[0] ? get_byte(cur_cnt_a[port_ch], ff_hi)
                                  : get_byte(cur_addr_a[port_ch], ff_hi);
        end else begin
            unique case (io_port)
                OFS_CMD_STS:  io_rdata = sts_q;
                OFS_MRESET:   io_rdata = tmp_q;
                OFS_MASK_ALL: io_rdata = BW'(mask_o);
                default:      io_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_reg_if_chk.sv
module dma_reg_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] io_port,
    input logic       io_rd,
    input logic       io_wr,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic [7:0] cmd_o,
    input logic [3:0] mask_o,
    input logic       ff_hi
);
    assert_ptr_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !io_port[3]) |=> (ff_hi != $past(ff_hi)));

    assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == 4'hC) |=> !ff_hi);

    assert_mask_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == 4'hA) |=> (mask_o[$past(io_wdata[1:0])] == $past(io_wdata[2])));

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == 4'hF) |=> (mask_o == $past(io_wdata[3:0])));

    assert_mreset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == 4'hD) |=> (mask_o == 4'hF && cmd_o == 8'h00 && !ff_hi));

    assert_mask_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == 4'hE) |=> (mask_o == 4'h0));

    assert_cmd_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == 4'h8) |=> (cmd_o == $past(io_wdata)));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_port == 4'h9 || io_port == 4'hA || io_port == 4'hB ||
         io_port == 4'hC || io_port == 4'hE) |-> (io_rdata == 8'h00));
endmodule

bind dma_reg_if dma_reg_if_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_port  (io_port),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .cmd_o    (cmd_o),
    .mask_o   (mask_o),
    .ff_hi    (ff_hi)
);

// File: tb/dma_reg_if_bench.sv
module dma_reg_if_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_port = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        eng_upd = 1'b0;
    logic [1:0]  eng_chan = '0;
    logic [15:0] eng_addr = '0, eng_cnt = '0;
    logic        eng_sts_wr = 1'b0, eng_tmp_wr = 1'b0;
    logic [7:0]  eng_sts = '0, eng_tmp = '0;
    logic [7:0]  cmd_o;
    logic [3:0]  req_o, mask_o;
    logic [31:0] mode_o;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

    always #4 clk = ~clk;

    dma_reg_if u_dma_reg_if (.*);

    // bench model
    logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
    logic [7:0]  m_mode[4], m_cmd, m_sts, m_tmp;
    logic [3:0]  m_req, m_mask;
    logic        m_ff;
    int n_chk = 0, n_fail = 0;

    task automatic mdl_reset();
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = '0; m_ca[i] = '0; m_bc[i] = '0; m_cc[i] = '0; m_mode[i] = '0;
        end
        m_cmd = '0; m_sts = '0; m_tmp = '0; m_req = '0; m_mask = 4'hF; m_ff = 1'b0;
    endtask

    function automatic logic [15:0] setb(logic [15:0] o, logic [7:0] b, logic hi);
        return hi ? {b, o[7:0]} : {o[15:8], b};
    endfunction

    function automatic logic [7:0] exp_rd(logic [3:0] p);
        logic [15:0] v;
        if (!p[3]) begin
            v = p[0] ? m_cc[p[2:1]] : m_ca[p[2:1]];
            return m_ff ? v[15:8] : v[7:0];
        end
        case (p)
            4'h8: return m_sts;
            4'hD: return m_tmp;
            4'hF: return {4'h0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_state(string tag);
        logic [63:0] eba, eca, ebc, ecc;
        logic [31:0] emd;
        for (int i = 0; i < 4; i++) begin
            eba[i*16 +: 16] = m_ba[i]; eca[i*16 +: 16] = m_ca[i];
            ebc[i*16 +: 16] = m_bc[i]; ecc[i*16 +: 16] = m_cc[i];
            emd[i*8 +: 8] = m_mode[i];
        end
        n_chk++;
        if (base_addr_o !== eba || cur_addr_o !== eca || base_cnt_o !== ebc ||
            cur_cnt_o !== ecc || mode_o !== emd || cmd_o !== m_cmd ||
            req_o !== m_req || mask_o !== m_mask) begin
            n_fail++;
            $display("FAIL %s state: ba=%h ca=%h bc=%h cc=%h md=%h cmd=%h req=%h msk=%h exp ba=%h ca=%h bc=%h cc=%h md=%h cmd=%h req=%h msk=%h",
                     tag, base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o, mode_o, cmd_o, req_o, mask_o,
                     eba, eca, ebc, ecc, emd, m_cmd, m_req, m_mask);
        end
    endtask

    // one bus cycle with optional engine activity
    task automatic cyc(logic wr, logic rd, logic [3:0] p, logic [7:0] d,
                       logic eu, logic [1:0] ech, logic [15:0] ea, logic [15:0] ec,
                       logic sw, logic [7:0] sd, logic tw, logic [7:0] td, string tag);
        logic hit_a, hit_c;
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_port = p; io_wdata = d;
        eng_upd = eu; eng_chan = ech; eng_addr = ea; eng_cnt = ec;
        eng_sts_wr = sw; eng_sts = sd; eng_tmp_wr = tw; eng_tmp = td;
        #2;
        if (rd) begin
            n_chk++;
            if (io_rdata !== exp_rd(p)) begin
                n_fail++;
                $display("FAIL %s read port %h: got %h exp %h", tag, p, io_rdata, exp_rd(p));
            end
        end
        @(posedge clk);
        #1;
        hit_a = wr && !p[3] && !p[0] && (p[2:1] == ech);
        hit_c = wr && !p[3] &&  p[0] && (p[2:1] == ech);
        if (tw) m_tmp = td;
        if (sw) m_sts = sd;
        if (eu) begin
            if (!hit_a) m_ca[ech] = ea;
            if (!hit_c) m_cc[ech] = ec;
        end
        if (rd && !p[3]) m_ff = ~m_ff;
        if (wr) begin
            if (!p[3]) begin
                if (!p[0]) begin
                    m_ba[p[2:1]] = setb(m_ba[p[2:1]], d, m_ff);
                    m_ca[p[2:1]] = setb(m_ca[p[2:1]], d, m_ff);
                end else begin
                    m_bc[p[2:1]] = setb(m_bc[p[2:1]], d, m_ff);
                    m_cc[p[2:1]] = setb(m_cc[p[2:1]], d, m_ff);
                end
                m_ff = ~m_ff;
            end else begin
                case (p)
                    4'h8: m_cmd = d;
                    4'h9: m_req[d[1:0]] = d[2];
                    4'hA: m_mask[d[1:0]] = d[2];
                    4'hB: m_mode[d[1:0]] = {d[7:2], 2'b00};
                    4'hC: m_ff = 1'b0;
                    4'hD: begin m_cmd = '0; m_mask = 4'hF; m_ff = 1'b0; m_sts = '0; m_req = '0; end
                    4'hE: m_mask = '0;
                    4'hF: m_mask = d[3:0];
                    default: ;
                endcase
            end
        end
        check_state(tag);
    endtask

    task automatic wr_p(logic [3:0] p, logic [7:0] d, string tag);
        cyc(1, 0, p, d, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rd_p(logic [3:0] p, string tag);
        cyc(0, 1, p, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout exp done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2 check_state("R1");
        rd_p(4'h0, "R1");
        // address and count bytes
        wr_p(4'h2, 8'h34, "R2"); wr_p(4'h2, 8'h12, "R2");
        rd_p(4'h2, "R3"); rd_p(4'h2, "R3");
        wr_p(4'h5, 8'hCD, "R3"); wr_p(4'h5, 8'hAB, "R3");
        rd_p(4'h5, "R3"); rd_p(4'h5, "R3");
        // pointer clear
        wr_p(4'h0, 8'h99, "R4"); wr_p(4'hC, 8'h00, "R4"); rd_p(4'h2, "R4");
        rd_p(4'h3, "R4");
        // mode and masks
        wr_p(4'hB, 8'h5A, "R5"); wr_p(4'hB, 8'hFF, "R5");
        wr_p(4'hA, 8'h01, "R6"); wr_p(4'hA, 8'h02, "R6"); wr_p(4'hA, 8'h06, "R6");
        wr_p(4'hF, 8'hA5, "R7"); rd_p(4'hF, "R7");
        wr_p(4'hE, 8'hFF, "R9"); rd_p(4'hF, "R9");
        // command, request, status, temporary
        wr_p(4'h8, 8'h44, "R10"); wr_p(4'h9, 8'h06, "R10"); wr_p(4'h9, 8'h07, "R10");
        wr_p(4'h9, 8'h02, "R10");
        cyc(0, 1, 4'h8, 0, 0, 0, 0, 0, 1, 8'h3C, 1, 8'h77, "R12");
        rd_p(4'h8, "R10"); rd_p(4'hD, "R8");
        for (int p = 9; p <= 14; p++) if (p != 13) rd_p(4'(p), "R10");
        // master reset with pointer high
        wr_p(4'h6, 8'h11, "R8"); wr_p(4'hD, 8'h00, "R8"); rd_p(4'h8, "R8");
        // engine update and collisions
        cyc(0, 0, 0, 0, 1, 2'd3, 16'hBEEF, 16'h0102, 0, 0, 0, 0, "R11");
        rd_p(4'h6, "R11"); rd_p(4'h7, "R11");
        cyc(1, 0, 4'h2, 8'h55, 1, 2'd1, 16'hF00D, 16'h7777, 0, 0, 0, 0, "R11");
        cyc(1, 0, 4'h3, 8'h66, 1, 2'd1, 16'hCAFE, 16'h8888, 0, 0, 0, 0, "R11");
        cyc(1, 0, 4'hD, 0, 0, 0, 0, 0, 1, 8'hEE, 0, 0, "R12");
        rd_p(4'h8, "R12");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h5D, 0, 0, "R12");
        rd_p(4'h8, "R12");
        // random traffic
        for (int i = 0; i < 400; i++) begin
            int kind;
            logic [3:0] p;
            kind = $urandom_range(0, 3);
            p = 4'($urandom_range(0, 15));
            cyc(kind == 0 || kind == 3, kind == 1, p, 8'($urandom),
                $urandom_range(0, 2) == 0, 2'($urandom), 16'($urandom), 16'($urandom),
                $urandom_range(0, 7) == 0, 8'($urandom),
                $urandom_range(0, 7) == 0, 8'($urandom), "R11");
        end
        @(negedge clk);
        io_wr = 0; io_rd = 0; eng_upd = 0; eng_sts_wr = 0; eng_tmp_wr = 0;
        finish_run();
    end
endmodule